// File: doc/BRIEF.md
# Branch and Jump Resolution Unit

This block works out where control goes next for a 32-bit instruction set with a single branch delay slot. Each cycle it can accept one instruction word, that instruction's program counter, and the two source register values the register file read for it. One cycle later it reports a registered result:
- whether the transfer is taken;
- the fetch address that follows the delay slot;
- whether the delay-slot instruction must be annulled;
- a link-register write request.

It also flags an undefined code in the register-immediate condition group. Instructions that do not transfer control pass through as plain sequential flow.

The block covers:
- the two-register equality branches;
- the sign/zero tests on one register;
- the register-immediate condition group;
- the absolute jumps.

Each of these comes in ordinary, linking and "likely" variants. A likely branch annuls its delay slot only when it is not taken. The linking forms of the condition group write the return address whether or not the branch is taken. Fetching, executing the delay slot and the register file itself belong to the surrounding pipeline.

Top module: `ctl_xfer_resolve`

## Requirements
- R1: `out_valid` is high in the cycle after each cycle with `in_valid` high, and low otherwise. A synchronous active-high `rst` clears `out_valid` and `out_undef`.
- R2: A taken conditional branch reports `out_next_pc` = PC + 4 + (sign-extended instruction bits 15:0 shifted left by 2).
- R3: Primary opcode (bits 31:26) 2 and 3 are absolute jumps. They are always taken, and `out_next_pc` = {PC[31:28], instruction bits 25:0, 2'b00}.
- R4: Opcode 4 is taken when rs == rt, and opcode 5 when rs != rt. Opcodes 20 and 21 are their likely forms.
- R5: Opcode 6 is taken when rs is negative or zero, and opcode 7 when rs is positive and nonzero. rt is ignored. Opcodes 22 and 23 are their likely forms.
- R6: Opcode 1 selects the condition group by bits 20:16. Code bit 0 picks the test: 0 means rs < 0 and 1 means rs >= 0. Bit 1 marks a likely form and bit 4 marks a linking form. The valid codes are 0x00-0x03 and 0x10-0x13.
- R7: A likely branch that is not taken sets `out_annul` = 1 with `out_next_pc` = PC + 8. A taken likely branch has `out_annul` = 0.
- R8: An ordinary branch that is not taken has `out_annul` = 0 and `out_next_pc` = PC + 8.
- R9: Opcode 3 and the linking condition-group codes set `out_link_we` with `out_link_val` = PC + 8 and `out_link_idx` = 31, whether the branch is taken or not. No other instruction links.
- R10: An opcode-1 word whose code has bits 3:2 nonzero sets `out_undef`. It is not taken, does not link or annul, and reports `out_next_pc` = PC + 4.
- R11: Any opcode other than 1-7 and 20-23 reports not taken, no annul, no link, no undef, and `out_next_pc` = PC + 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input word is present this cycle |
| in_instr | input | 32 | Instruction word |
| in_pc | input | XLEN | Address of the instruction |
| in_rs_val | input | XLEN | Value of the rs source register |
| in_rt_val | input | XLEN | Value of the rt source register |
| out_valid | output | 1 | One-cycle result strobe |
| out_taken | output | 1 | Transfer is taken |
| out_next_pc | output | XLEN | Fetch address after the delay slot (PC + 4 for non-transfers) |
| out_annul | output | 1 | Squash the delay-slot instruction |
| out_link_we | output | 1 | Link register write enable |
| out_link_idx | output | REG_IDX_W | Link register index |
| out_link_val | output | XLEN | Return address to write |
| out_undef | output | 1 | Undefined condition-group code |

## Verification
The bench builds the unit with XLEN = 32, LINK_REG = 31 and EQ_STYLE = 1. This selects the subtractor-based equality variant, so that path's zero detect is exercised on equal, unequal, zero and sign-bit operands. Random words cover every opcode together with fully random condition codes, so both valid and undefined codes come up. Directed words place the jump index at its all-ones limit under a high PC region and use a negative branch offset. Back-to-back valid inputs and an idle gap check the strobe timing.

// File: rtl/ctlx_pkg.sv
package ctlx_pkg;

   localparam logic [5:0] OPC_CONDGRP = 6'd1;
   localparam logic [5:0] OPC_JUMP    = 6'd2;
   localparam logic [5:0] OPC_JUMPLNK = 6'd3;

   typedef enum logic [2:0] {
      XK_NONE,
      XK_JUMP,
      XK_CMP2,
      XK_SIGNZ,
      XK_CONDGRP
   } xfer_kind_e;

   typedef enum logic [2:0] {
      TST_EQ,
      TST_NE,
      TST_LEZ,
      TST_GTZ,
      TST_LTZ,
      TST_GEZ,
      TST_ALWAYS,
      TST_NEVER
   } xfer_test_e;

   typedef struct packed {
      xfer_kind_e kind;
      xfer_test_e test;
      logic       likely;
      logic       link;
      logic       undef;
   } xfer_dec_t;

endpackage

// File: rtl/ctlx_decode.sv
module ctlx_decode
   import ctlx_pkg::*;
(
   input  logic [5:0] opc,
   input  logic [4:0] code,
   output xfer_dec_t  dec
);

   always_comb begin
      dec.kind   = XK_NONE;
      dec.test   = TST_NEVER;
      dec.likely = 1'b0;
      dec.link   = 1'b0;
      dec.undef  = 1'b0;
      if (opc == OPC_JUMP || opc == OPC_JUMPLNK) begin
         dec.kind = XK_JUMP;
         dec.test = TST_ALWAYS;
         dec.link = (opc == OPC_JUMPLNK);
      end else if (opc[5] == 1'b0 && opc[3:2] == 2'b01) begin
         // opcodes 4..7 and their likely twins 20..23
         dec.kind   = opc[1] ? XK_SIGNZ : XK_CMP2;
         dec.likely = opc[4];
         unique case (opc[1:0])
            2'd0:    dec.test = TST_EQ;
            2'd1:    dec.test = TST_NE;
            2'd2:    dec.test = TST_LEZ;
            default: dec.test = TST_GTZ;
         endcase
      end else if (opc == OPC_CONDGRP) begin
         if (code[3:2] == 2'b00) begin
            dec.kind   = XK_CONDGRP;
            dec.test   = code[0] ? TST_GEZ : TST_LTZ;
            dec.likely = code[1];
            dec.link   = code[4];
         end else begin
            dec.undef = 1'b1;
         end
      end
   end

endmodule

// File: rtl/ctlx_cond.sv
module ctlx_cond
   import ctlx_pkg::*;
#(
   parameter int XLEN     = 32,
   parameter int EQ_STYLE = 0
)(
   input  logic [XLEN-1:0] a,
   input  logic [XLEN-1:0] b,
   input  xfer_test_e      test,
   output logic            hit
);

   logic same;
   logic a_zero;
   logic a_neg;

   generate
      if (EQ_STYLE == 0) begin : g_eq_direct
         assign same = (a == b);
      end else begin : g_eq_sub
         logic [XLEN-1:0] diff;
         assign diff = a - b;
         assign same = ~|diff;
      end
   endgenerate

   assign a_zero = ~|a;
   assign a_neg  = a[XLEN-1];

   always_comb begin
      unique case (test)
         TST_EQ:     hit = same;
         TST_NE:     hit = ~same;
         TST_LEZ:    hit = a_neg | a_zero;
         TST_GTZ:    hit = ~a_neg & ~a_zero;
         TST_LTZ:    hit = a_neg;
         TST_GEZ:    hit = ~a_neg;
         TST_ALWAYS: hit = 1'b1;
         default:    hit = 1'b0;
      endcase
   end

endmodule

// File: rtl/ctlx_target.sv
module ctlx_target #(
   parameter int XLEN = 32
)(
   input  logic [XLEN-1:0] pc,
   input  logic [25:0]     idx,
   output logic [XLEN-1:0] br_tgt,
   output logic [XLEN-1:0] jmp_tgt,
   output logic [XLEN-1:0] seq4,
   output logic [XLEN-1:0] seq8
);

   localparam int OFF_W  = 16;
   localparam int HIGH_W = XLEN - 28;

   logic [XLEN-1:0] off_sx;

   assign off_sx  = {{(XLEN-OFF_W-2){idx[OFF_W-1]}}, idx[OFF_W-1:0], 2'b00};
   assign seq4    = pc + XLEN'(4);
   assign seq8    = pc + XLEN'(8);
   assign br_tgt  = seq4 + off_sx;
   assign jmp_tgt = {pc[XLEN-1 -: HIGH_W], idx, 2'b00};

endmodule

// File: rtl/ctl_xfer_resolve.sv
module ctl_xfer_resolve
   import ctlx_pkg::*;
#(
   parameter int XLEN      = 32,
   parameter int REG_IDX_W = 5,
   parameter int LINK_REG  = 31,
   parameter int EQ_STYLE  = 0
)(
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 in_valid,
   input  logic [31:0]          in_instr,
   input  logic [XLEN-1:0]      in_pc,
   input  logic [XLEN-1:0]      in_rs_val,
   input  logic [XLEN-1:0]      in_rt_val,
   output logic                 out_valid,
   output logic                 out_taken,
   output logic [XLEN-1:0]      out_next_pc,
   output logic                 out_annul,
   output logic                 out_link_we,
   output logic [REG_IDX_W-1:0] out_link_idx,
   output logic [XLEN-1:0]      out_link_val,
   output logic                 out_undef
);

   localparam logic [REG_IDX_W-1:0] LINK_IDX = REG_IDX_W'(LINK_REG);

   generate
      if (XLEN < 32) begin : g_bad_xlen
         $error("ctl_xfer_resolve: XLEN must be at least 32");
      end
      if (LINK_REG <= 0 || LINK_REG >= (1 << REG_IDX_W)) begin : g_bad_link
         $error("ctl_xfer_resolve: LINK_REG must be a nonzero register index");
      end
      if (EQ_STYLE < 0 || EQ_STYLE > 1) begin : g_bad_eq
         $error("ctl_xfer_resolve: EQ_STYLE must be 0 or 1");
      end
   endgenerate

   xfer_dec_t       dec;
   logic            hit;
   logic [XLEN-1:0] br_tgt, jmp_tgt, seq4, seq8;
   logic            is_xfer;
   logic            taken_c, annul_c;
   logic [XLEN-1:0] next_c;

   ctlx_decode u_dec (
      .opc  (in_instr[31:26]),
      .code (in_instr[20:16]),
      .dec  (dec)
   );

   ctlx_cond #(.XLEN(XLEN), .EQ_STYLE(EQ_STYLE)) u_cond (
      .a    (in_rs_val),
      .b    (in_rt_val),
      .test (dec.test),
      .hit  (hit)
   );

   ctlx_target #(.XLEN(XLEN)) u_tgt (
      .pc      (in_pc),
      .idx     (in_instr[25:0]),
      .br_tgt  (br_tgt),
      .jmp_tgt (jmp_tgt),
      .seq4    (seq4),
      .seq8    (seq8)
   );

   assign is_xfer = (dec.kind != XK_NONE);
   assign taken_c = is_xfer & hit;
   assign annul_c = is_xfer & dec.likely & ~hit;

   always_comb begin
      if (!is_xfer)
         next_c = seq4;
      else if (!hit)
         next_c = seq8;
      else if (dec.kind == XK_JUMP)
         next_c = jmp_tgt;
      else
         next_c = br_tgt;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid    <= 1'b0;
         out_undef    <= 1'b0;
         out_taken    <= 1'b0;
         out_annul    <= 1'b0;
         out_link_we  <= 1'b0;
         out_next_pc  <= '0;
         out_link_val <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            out_undef    <= dec.undef;
            out_taken    <= taken_c;
            out_annul    <= annul_c;
            out_link_we  <= dec.link;
            out_next_pc  <= next_c;
            out_link_val <= seq8;
         end
      end
   end

   assign out_link_idx = LINK_IDX;

   AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> out_valid); // R1
   AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> !out_valid); // R1
   AST_JUMP_TAKEN: assert property (@(posedge clk) disable iff (rst)
      in_valid && (in_instr[31:27] == 5'b00001) |=> out_taken); // R3
   AST_ANNUL_NOT_TAKEN: assert property (@(posedge clk) disable iff (rst)
      out_valid && out_annul |-> !out_taken); // R7
   AST_LINK_RETURN: assert property (@(posedge clk) disable iff (rst)
      out_valid && out_link_we |-> out_link_val == $past(in_pc) + XLEN'(8)); // R9
   AST_UNDEF_QUIET: assert property (@(posedge clk) disable iff (rst)
      out_valid && out_undef |-> !out_taken && !out_link_we && !out_annul); // R10

endmodule

// File: tb/sim_ctl_xfer_resolve.sv
module sim_ctl_xfer_resolve;

   logic        clk = 1'b0;
   logic        rst;
   logic        in_valid;
   logic [31:0] in_instr, in_pc, in_rs_val, in_rt_val;
   logic        out_valid, out_taken, out_annul, out_link_we, out_undef;
   logic [31:0] out_next_pc, out_link_val;
   logic [4:0]  out_link_idx;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;   // 125 MHz

   ctl_xfer_resolve #(.XLEN(32), .REG_IDX_W(5), .LINK_REG(31), .EQ_STYLE(1)) u0 (
      .clk, .rst, .in_valid, .in_instr, .in_pc, .in_rs_val, .in_rt_val,
      .out_valid, .out_taken, .out_next_pc, .out_annul, .out_link_we,
      .out_link_idx, .out_link_val, .out_undef
   );

   task automatic chk(input string req, input string what,
                      input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s %s got %h exp %h", req, what, got, exp);
      end
   endtask

   function automatic void ref_model(
      input  logic [31:0] ins, pc, a, b,
      output logic t, output logic [31:0] n, output logic an,
      output logic lw, output logic u, output string tag, output logic lk);
      logic [5:0]  opc  = ins[31:26];
      logic [4:0]  code = ins[20:16];
      logic [31:0] bt   = pc + 32'd4 + {{14{ins[15]}}, ins[15:0], 2'b00};
      logic [31:0] jt   = {pc[31:28], ins[25:0], 2'b00};
      logic        isb  = 1'b0;
      logic        c    = 1'b0;
      t = 0; n = pc + 32'd4; an = 0; lw = 0; u = 0; lk = 0; tag = "R11";
      case (opc)
         6'd2, 6'd3: begin t = 1; n = jt; lw = (opc == 6'd3); tag = "R3"; end
         6'd4, 6'd20: begin isb = 1; c = (a == b); lk = opc[4]; tag = "R4"; end
         6'd5, 6'd21: begin isb = 1; c = (a != b); lk = opc[4]; tag = "R4"; end
         6'd6, 6'd22: begin isb = 1; c = a[31] || a == 0; lk = opc[4]; tag = "R5"; end
         6'd7, 6'd23: begin isb = 1; c = !a[31] && a != 0; lk = opc[4]; tag = "R5"; end
         6'd1: begin
            if (code inside {5'h00, 5'h01, 5'h02, 5'h03, 5'h10, 5'h11, 5'h12, 5'h13}) begin
               isb = 1; tag = "R6";
               c  = code[0] ? !a[31] : a[31];
               lk = code[1];
               lw = code[4];
            end else begin
               u = 1; tag = "R10";
            end
         end
         default: ;
      endcase
      if (isb) begin
         t  = c;
         n  = c ? bt : pc + 32'd8;
         an = lk && !c;
      end
   endfunction

   task automatic apply(input logic [31:0] ins, pc, a, b);
      logic e_t, e_an, e_lw, e_u, e_lk;
      logic [31:0] e_n;
      string tg, ntag;
      ref_model(ins, pc, a, b, e_t, e_n, e_an, e_lw, e_u, tg, e_lk);
      @(negedge clk);
      in_valid = 1'b1; in_instr = ins; in_pc = pc; in_rs_val = a; in_rt_val = b;
      @(posedge clk); #2;
      ntag = (e_t && tg != "R3") ? "R2" : (e_an ? "R7" : tg);
      chk("R1", "valid", 32'(out_valid), 32'd1);
      chk(tg, "taken", 32'(out_taken), 32'(e_t));
      chk(ntag, "next_pc", out_next_pc, e_n);
      chk(e_lk ? "R7" : "R8", "annul", 32'(out_annul), 32'(e_an));
      chk("R9", "link_we", 32'(out_link_we), 32'(e_lw));
      if (e_lw) begin
         chk("R9", "link_val", out_link_val, pc + 32'd8);
         chk("R9", "link_idx", 32'(out_link_idx), 32'd31);
      end
      chk("R10", "undef", 32'(out_undef), 32'(e_u));
   endtask

   task automatic idle();
      @(negedge clk);
      in_valid = 1'b0;
      @(posedge clk); #2;
      chk("R1", "valid_idle", 32'(out_valid), 32'd0);
   endtask

   function automatic logic [31:0] pick_val();
      case ($urandom % 4)
         0: return 32'd0;
         1: return $urandom;
         2: return 32'h8000_0000 | $urandom;
         default: return 32'd1;
      endcase
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL R1 watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [5:0] opcs [13];
      void'($urandom(32'd20250611));
      opcs = '{6'd0, 6'd1, 6'd2, 6'd3, 6'd4, 6'd5, 6'd6, 6'd7,
               6'd20, 6'd21, 6'd22, 6'd23, 6'd8};
      rst = 1'b1; in_valid = 1'b0;
      in_instr = '0; in_pc = '0; in_rs_val = '0; in_rt_val = '0;
      repeat (3) @(posedge clk);
      #2;
      chk("R1", "reset_valid", 32'(out_valid), 32'd0);
      chk("R1", "reset_undef", 32'(out_undef), 32'd0);
      @(negedge clk); rst = 1'b0;

      // R2 R4: equal compare, negative offset
      apply({6'd4, 5'd1, 5'd2, 16'hFFFE}, 32'h0000_1000, 32'd5, 32'd5);
      // R8: ordinary not taken
      apply({6'd5, 5'd1, 5'd2, 16'h0010}, 32'h0000_2000, 32'd7, 32'd7);
      // R7: likely not taken, then taken
      apply({6'd20, 5'd1, 5'd2, 16'h0010}, 32'h0000_3000, 32'd1, 32'd2);
      apply({6'd21, 5'd1, 5'd2, 16'h0010}, 32'h0000_3000, 32'd1, 32'd2);
      // R5: sign/zero tests on zero and negative
      apply({6'd6, 5'd3, 5'd9, 16'h0004}, 32'h0000_4000, 32'd0, 32'hFFFF_FFFF);
      apply({6'd7, 5'd3, 5'd9, 16'h0004}, 32'h0000_4000, 32'd0, 32'd1);
      apply({6'd7, 5'd3, 5'd9, 16'h0004}, 32'h0000_4000, 32'h8000_0000, 32'd1);
      apply({6'd23, 5'd3, 5'd9, 16'h0004}, 32'h0000_4000, 32'h7FFF_FFFF, 32'd1);
      // R3: jumps at index limit
      apply({6'd2, 26'h3FF_FFFF}, 32'hA000_0000, 32'd0, 32'd0);
      apply({6'd3, 26'h000_0040}, 32'hF123_4560, 32'd0, 32'd0);
      // R6 R9: linking condition group not taken still links
      apply({6'd1, 5'd4, 5'h10, 16'h0020}, 32'h0000_5000, 32'd3, 32'd0);
      apply({6'd1, 5'd4, 5'h13, 16'h0020}, 32'h0000_5000, 32'h8000_0001, 32'd0);
      apply({6'd1, 5'd4, 5'h01, 16'h8000}, 32'h0001_0000, 32'd0, 32'd0);
      // R10: undefined codes
      apply({6'd1, 5'd4, 5'h04, 16'h0020}, 32'h0000_6000, 32'd0, 32'd0);
      apply({6'd1, 5'd4, 5'h1F, 16'h0020}, 32'h0000_6000, 32'd0, 32'd0);
      // R11: non-transfer opcodes
      apply({6'd0, 26'h3FF_FFFF}, 32'h0000_7000, 32'd0, 32'd0);
      apply({6'd8, 26'h000_1234}, 32'h0000_7004, 32'd0, 32'd0);
      idle();
      idle();

      for (int i = 0; i < 3000; i++) begin
         logic [31:0] w, a, b, pc;
         w = $urandom;
         w[31:26] = ($urandom % 8 == 0) ? 6'($urandom) : opcs[$urandom % 13];
         if (w[31:26] == 6'd1 && $urandom % 2 == 0)
            w[20:16] = {$urandom % 2 == 0 ? 1'b0 : 1'b1, 2'b00, 2'($urandom)};
         a  = pick_val();
         b  = ($urandom % 2 == 0) ? a : pick_val();
         pc = {$urandom} & 32'hFFFF_FFFC;
         apply(w, pc, a, b);
         if ($urandom % 16 == 0) idle();
      end
      idle();

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule